// File: doc/BRIEF.md
# Strap-Configured Serial Stereo Audio Receiver

This block accepts a three-wire serial stereo audio stream (bit clock, word select, serial data) and turns it into parallel left and right samples. Two static strap pins pick one of four framings: the classic two-channel serial format with its one-bit delay, MSB-first left-justified framing, and right-justified framing with either a 16-bit or a 24-bit word. An unconnected strap reads as 1 and a grounded one as 0. The three serial wires are brought into the system clock domain by a parameterised synchroniser, and the bit clock is sampled on its rising edges.

Each received word comes out sign-preserving and left-aligned in a `WORD_W`-bit field, with zeros below the last received bit. Once a left and a right word of the same frame are complete, both are presented together with a single-cycle valid strobe. In the MSB-first framings the word length follows the number of bit clocks in each half-frame, up to `WORD_W`. In the right-justified framings only the last 16 or 24 bits before the word-select edge count. To change the straps, hold the block in reset.

Top module: `serial_audio_rx`

## Requirements
- R1: The strap code {strap_hi, strap_lo} selects the framing: 2'b11 two-channel serial with one-bit delay, 2'b01 left-justified, 2'b10 right-justified 16-bit, 2'b00 right-justified 24-bit.
- R2: In the one-bit-delay framing, ser_ws low marks the left channel, and the MSB is the bit sampled on the second bit-clock rise after a ser_ws change.
- R3: In the left-justified framing, ser_ws high marks the left channel, and the MSB is the bit sampled on the first bit-clock rise after a ser_ws change. A half-frame of n bit clocks (n up to 32) yields an n-bit word.
- R4: In the right-justified framings, ser_ws high marks the left channel and the LSB is the last bit before a ser_ws change. Only the last 16 (code 2'b10) or 24 (code 2'b00) bits of each half-frame are kept, and earlier padding bits have no effect on the output.
- R5: The first received bit of a word lands at bit WORD_W-1 of the output, and every bit below the word is 0.
- R6: smp_valid pulses for one cycle once per stereo pair, after that pair's right word is complete. smp_left and smp_right change only with that pulse. The partial half-frame in progress when reset is released produces no output.
- R7: smp_valid is high in the clock cycle that follows the (SYNC_STAGES+3)-th rising clk edge after ser_clk rises with the first bit of the next left half-frame.
- R8: While rst_n is low and after its release, smp_valid, smp_left and smp_right are 0 until the first pair is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than ser_clk |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock; data sampled on its rising edge |
| ser_ws | input | 1 | Word select (channel marker) |
| ser_dat | input | 1 | Serial data, MSB first |
| strap_hi | input | 1 | Upper strap bit of the framing code |
| strap_lo | input | 1 | Lower strap bit of the framing code |
| smp_left | output | WORD_W | Left sample, left-aligned |
| smp_right | output | WORD_W | Right sample, left-aligned |
| smp_valid | output | 1 | One-cycle strobe for each new stereo pair |

## Verification
A pair is due a fixed number of clk cycles after the ser_clk rise that closes the right half-frame: SYNC_STAGES cycles of synchronisation, one for edge detection, one for the framer and one for the pairing register. The bench drives the serial lines on falling clk edges. For each closing rise it queues the expected pair with a due cycle of the current cycle plus SYNC_STAGES+3. On every falling edge it compares smp_valid against that queue, so a pulse one cycle early, one cycle late, missing or extra is reported. The sample values are checked in the same cycle as the pulse.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

   typedef enum logic [1:0] {
      FMT_RJ_WIDE   = 2'b00,
      FMT_LJ        = 2'b01,
      FMT_RJ_NARROW = 2'b10,
      FMT_DELAYED   = 2'b11
   } fmt_e;

   localparam int RJ_NARROW_BITS = 16;
   localparam int RJ_WIDE_BITS   = 24;

   function automatic logic fmt_is_rj(input fmt_e f);
      return (f == FMT_RJ_WIDE) || (f == FMT_RJ_NARROW);
   endfunction

   function automatic int rj_bits(input fmt_e f);
      return (f == FMT_RJ_NARROW) ? RJ_NARROW_BITS : RJ_WIDE_BITS;
   endfunction

endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_ws,
   input  logic ser_dat,
   output logic bit_stb,
   output logic bit_val,
   output logic ws_val
);
   logic clk_s, ws_s, dat_s;
   logic clk_prev;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               clk_s <= 1'b0;
               ws_s  <= 1'b0;
               dat_s <= 1'b0;
            end else begin
               clk_s <= ser_clk;
               ws_s  <= ser_ws;
               dat_s <= ser_dat;
            end
         end
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] clk_c, ws_c, dat_c;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               clk_c <= '0;
               ws_c  <= '0;
               dat_c <= '0;
            end else begin
               clk_c <= {clk_c[SYNC_STAGES-2:0], ser_clk};
               ws_c  <= {ws_c[SYNC_STAGES-2:0], ser_ws};
               dat_c <= {dat_c[SYNC_STAGES-2:0], ser_dat};
            end
         end
         assign clk_s = clk_c[SYNC_STAGES-1];
         assign ws_s  = ws_c[SYNC_STAGES-1];
         assign dat_s = dat_c[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_prev <= 1'b0;
         bit_stb  <= 1'b0;
         bit_val  <= 1'b0;
         ws_val   <= 1'b0;
      end else begin
         clk_prev <= clk_s;
         bit_stb  <= clk_s & ~clk_prev;
         if (clk_s & ~clk_prev) begin
            bit_val <= dat_s;
            ws_val  <= ws_s;
         end
      end
   end
endmodule

// File: rtl/sar_framer.sv
module sar_framer
   import audrx_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_e              fmt,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              ws_val,
   output logic              word_stb,
   output logic              word_left,
   output logic [WORD_W-1:0] word_data
);
   localparam int CNT_W = $clog2(WORD_W) + 2;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = '1;

   logic              ws_hold;
   logic              side_q;
   logic              started;
   logic [WORD_W-1:0] sr;
   logic [CNT_W-1:0]  cnt;

   logic              is_rj;
   logic              left_now;
   logic              shift_en;
   logic [CNT_W-1:0]  n_bits;
   logic [WORD_W-1:0] msb_word;
   logic [WORD_W-1:0] lsb_word;

   always_comb begin
      is_rj    = fmt_is_rj(fmt);
      // delayed framing: channel follows the word select seen one bit earlier, inverted
      left_now = (fmt == FMT_DELAYED) ? ~ws_hold : ws_val;
      n_bits   = (cnt > CNT_FULL) ? CNT_FULL : cnt;
      shift_en = is_rj || (cnt < CNT_FULL);
      msb_word = sr << (WORD_W - int'(n_bits));
      lsb_word = sr << (WORD_W - rj_bits(fmt));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ws_hold   <= 1'b1;
         side_q    <= 1'b0;
         started   <= 1'b0;
         sr        <= '0;
         cnt       <= '0;
         word_stb  <= 1'b0;
         word_left <= 1'b0;
         word_data <= '0;
      end else begin
         word_stb <= 1'b0;
         if (bit_stb) begin
            ws_hold <= ws_val;
            if (left_now != side_q) begin
               side_q  <= left_now;
               started <= 1'b1;
               if (started) begin
                  word_stb  <= 1'b1;
                  word_left <= side_q;
                  word_data <= is_rj ? lsb_word : msb_word;
               end
               sr  <= {{(WORD_W-1){1'b0}}, bit_val};
               cnt <= CNT_W'(1);
            end else begin
               if (shift_en) sr <= {sr[WORD_W-2:0], bit_val};
               if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/sar_pairer.sv
module sar_pairer #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_stb,
   input  logic              word_left,
   input  logic [WORD_W-1:0] word_data,
   output logic [WORD_W-1:0] smp_left,
   output logic [WORD_W-1:0] smp_right,
   output logic              smp_valid
);
   logic [WORD_W-1:0] hold_l;
   logic              have_l;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l    <= '0;
         have_l    <= 1'b0;
         smp_left  <= '0;
         smp_right <= '0;
         smp_valid <= 1'b0;
      end else begin
         smp_valid <= 1'b0;
         if (word_stb) begin
            if (word_left) begin
               hold_l <= word_data;
               have_l <= 1'b1;
            end else if (have_l) begin
               smp_left  <= hold_l;
               smp_right <= word_data;
               smp_valid <= 1'b1;
               have_l    <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import audrx_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_ws,
   input  logic              ser_dat,
   input  logic              strap_hi,
   input  logic              strap_lo,
   output logic [WORD_W-1:0] smp_left,
   output logic [WORD_W-1:0] smp_right,
   output logic              smp_valid
);
   generate
      if (WORD_W < RJ_WIDE_BITS) begin : g_bad_width
         $error("serial_audio_rx: WORD_W must hold the widest right-justified word");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("serial_audio_rx: SYNC_STAGES must be at least 1");
      end
   endgenerate

   fmt_e              fmt;
   logic              b_stb, b_val, b_ws;
   logic              w_stb, w_left;
   logic [WORD_W-1:0] w_data;

   assign fmt = fmt_e'({strap_hi, strap_lo});

   sar_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .ser_clk(ser_clk), .ser_ws(ser_ws), .ser_dat(ser_dat),
      .bit_stb(b_stb), .bit_val(b_val), .ws_val(b_ws)
   );

   sar_framer #(.WORD_W(WORD_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .fmt(fmt),
      .bit_stb(b_stb), .bit_val(b_val), .ws_val(b_ws),
      .word_stb(w_stb), .word_left(w_left), .word_data(w_data)
   );

   sar_pairer #(.WORD_W(WORD_W)) u_pair (
      .clk(clk), .rst_n(rst_n),
      .word_stb(w_stb), .word_left(w_left), .word_data(w_data),
      .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid)
   );
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_hi,
   input logic              strap_lo,
   input logic              w_stb,
   input logic              w_left,
   input logic [WORD_W-1:0] smp_left,
   input logic [WORD_W-1:0] smp_right,
   input logic              smp_valid
);
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid); // R6

   AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> ($past(w_stb) && !$past(w_left))); // R6

   AST_LEFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> $stable(smp_left)); // R6

   AST_RIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> $stable(smp_right)); // R6

   AST_NARROW_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && {strap_hi, strap_lo} == 2'b10) |->
      (smp_left[WORD_W-17:0] == '0 && smp_right[WORD_W-17:0] == '0)); // R4

   AST_WIDE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && {strap_hi, strap_lo} == 2'b00) |->
      (smp_left[WORD_W-25:0] == '0 && smp_right[WORD_W-25:0] == '0)); // R4
endmodule

bind serial_audio_rx sar_checker #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
   .w_stb(w_stb), .w_left(w_left),
   .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
   localparam int SYNC  = 2;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_ws = 1'b0, ser_dat = 1'b0;
   logic strap_hi = 1'b1, strap_lo = 1'b1;
   logic [31:0] smp_left, smp_right;
   logic smp_valid;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   bit q_bit[$];
   bit q_left[$];
   logic [31:0] pend_l[$], pend_r[$];
   string pend_t[$];
   int due_q[$];
   logic [31:0] dl_q[$], dr_q[$];
   string dt_q[$];

   always #5 clk = ~clk;

   serial_audio_rx #(.WORD_W(32), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_ws(ser_ws), .ser_dat(ser_dat),
      .strap_hi(strap_hi), .strap_lo(strap_lo),
      .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > LIMIT && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 watchdog expired: got cycle %0d expected below %0d", cyc, LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // Reference comparison on every clock, sampled on the falling edge
   always @(negedge clk) begin : cmp
      bit exp_v;
      if (rst_n) begin
         exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
         if (smp_valid || exp_v) begin
            n_chk++;
            if (smp_valid !== exp_v) begin
               n_fail++;
               $display("FAIL R6 R7 valid timing at cycle %0d: got %b expected %b", cyc, smp_valid, exp_v);
            end else if (smp_left !== dl_q[0] || smp_right !== dr_q[0]) begin
               n_fail++;
               $display("FAIL %s R5 sample: got L=%h R=%h expected L=%h R=%h",
                        dt_q[0], smp_left, smp_right, dl_q[0], dr_q[0]);
            end
            if (exp_v) begin
               void'(due_q.pop_front()); void'(dl_q.pop_front());
               void'(dr_q.pop_front()); void'(dt_q.pop_front());
            end
         end
      end
   end

   task automatic put(input bit lf, input bit b);
      q_left.push_back(lf);
      q_bit.push_back(b);
   endtask

   // MSB-first framings (delayed and left-justified): slot bits per channel
   task automatic frm_msb(input int slot, input logic [31:0] l, input logic [31:0] r, input string tag);
      logic [31:0] mask;
      for (int k = 0; k < slot; k++) put(1'b1, l[31-k]);
      for (int k = 0; k < slot; k++) put(1'b0, r[31-k]);
      mask = (slot >= 32) ? 32'hFFFF_FFFF : ~(32'hFFFF_FFFF >> slot);
      pend_l.push_back(l & mask);
      pend_r.push_back(r & mask);
      pend_t.push_back(tag);
   endtask

   // Right-justified: padding (alternating, must be ignored) then w bits ending at the edge
   task automatic frm_rj(input int slot, input int w, input logic [31:0] l, input logic [31:0] r, input string tag);
      for (int k = 0; k < slot; k++) put(1'b1, (k < slot - w) ? ~k[0] : l[slot-1-k]);
      for (int k = 0; k < slot; k++) put(1'b0, (k < slot - w) ? k[0] : r[slot-1-k]);
      pend_l.push_back(l << (32 - w));
      pend_r.push_back(r << (32 - w));
      pend_t.push_back(tag);
   endtask

   task automatic start_fmt(input bit [1:0] code);
      @(negedge clk);
      {strap_hi, strap_lo} = code;
      rst_n = 1'b0;
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      n_chk++;
      if (smp_valid !== 1'b0 || smp_left !== 32'h0 || smp_right !== 32'h0) begin
         n_fail++;
         $display("FAIL R8 in reset: got v=%b L=%h R=%h expected 0", smp_valid, smp_left, smp_right);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (smp_valid !== 1'b0 || smp_left !== 32'h0 || smp_right !== 32'h0) begin
         n_fail++;
         $display("FAIL R8 after reset: got v=%b L=%h R=%h expected 0", smp_valid, smp_left, smp_right);
      end
      // lead-in: tail of a right half-frame, partial, never reported
      for (int k = 0; k < 5; k++) put(1'b0, k[0]);
   endtask

   task automatic play(input bit delayed);
      bit paired = 0;
      for (int k = 0; k < 3; k++) put(1'b1, 1'b1);
      for (int i = 0; i < q_bit.size(); i++) begin
         bit lr;
         if (delayed) lr = ~((i + 1 < q_bit.size()) ? q_left[i+1] : q_left[i]);
         else         lr = q_left[i];
         @(negedge clk);
         ser_clk = 1'b0; ser_dat = q_bit[i]; ser_ws = lr;
         repeat (3) @(negedge clk);
         @(negedge clk);
         ser_clk = 1'b1;
         if (i > 0 && q_left[i] && !q_left[i-1]) begin
            if (paired && pend_l.size() > 0) begin
               due_q.push_back(cyc + SYNC + 3);
               dl_q.push_back(pend_l.pop_front());
               dr_q.push_back(pend_r.pop_front());
               dt_q.push_back(pend_t.pop_front());
            end
            paired = 1;
         end
      end
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (12) @(negedge clk);
      n_chk++;
      if (due_q.size() != 0 || pend_l.size() != 0) begin
         n_fail++;
         $display("FAIL R6 pairs not delivered: got %0d left over expected 0", due_q.size() + pend_l.size());
      end
      q_bit.delete(); q_left.delete();
      pend_l.delete(); pend_r.delete(); pend_t.delete();
      due_q.delete(); dl_q.delete(); dr_q.delete(); dt_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);

      // R1 R2: code 11, delayed framing, left on low word select
      start_fmt(2'b11);
      frm_msb(32, 32'h8000_0001, 32'h7FFF_FFFE, "R1 R2 slot32");
      frm_msb(32, 32'hA5C3_3C5A, 32'h0123_4567, "R1 R2 slot32");
      frm_msb(32, 32'hFFFF_FFFF, 32'h0000_0000, "R1 R2 extremes");
      play(1'b1);
      start_fmt(2'b11);
      frm_msb(16, 32'hBEEF_0000, 32'h1234_0000, "R2 slot16");
      frm_msb(16, 32'h8001_0000, 32'h7FFE_0000, "R2 slot16");
      play(1'b1);

      // R1 R3: code 01, left-justified, adapting word length
      start_fmt(2'b01);
      frm_msb(32, 32'hDEAD_BEEF, 32'hCAFE_F00D, "R1 R3 slot32");
      frm_msb(32, 32'h0000_0001, 32'h8000_0000, "R3 slot32");
      play(1'b0);
      start_fmt(2'b01);
      frm_msb(24, 32'h8765_4321, 32'h1357_9BDF, "R3 R5 slot24");
      frm_msb(24, 32'hFFFF_FF00, 32'h0000_0100, "R3 R5 slot24");
      frm_msb(16, 32'hC0DE_9999, 32'h4242_7777, "R3 R5 slot16");
      play(1'b0);

      // R1 R4: code 10, right-justified 16-bit
      start_fmt(2'b10);
      frm_rj(32, 16, 32'h0000_8001, 32'h0000_7FFE, "R1 R4 rj16 slot32");
      frm_rj(32, 16, 32'h0000_ABCD, 32'h0000_1234, "R4 rj16 slot32");
      frm_rj(16, 16, 32'h0000_F0F0, 32'h0000_0F0F, "R4 rj16 slot16");
      play(1'b0);

      // R1 R4: code 00, right-justified 24-bit
      start_fmt(2'b00);
      frm_rj(32, 24, 32'h0080_0001, 32'h007F_FFFE, "R1 R4 rj24 slot32");
      frm_rj(32, 24, 32'h00A5_5A3C, 32'h0012_3456, "R4 rj24 slot32");
      play(1'b0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule